// File: doc/BRIEF.md
# Prioritized Request Admission Queue

This block sits in front of a memory controller and decides which of several requesters may place a transaction into a short in-order look-ahead queue. Each requester presents a valid flag, a priority level, an address and a read/write flag. In any cycle where the queue has a free slot, the block grants exactly one requester. The highest priority level present wins. Requesters that share the winning level are served in rotating order. A granted transaction is written into the queue in the same clock edge.

The queue holds at most four transactions. The cap keeps a late high-priority request from waiting behind a long chain of accepted low-priority work. When the queue is full, no requester is granted and nothing is remembered about the refused requests. Those requesters simply compete again in a later cycle, where a newly arrived higher-priority request can overtake them.

The downstream command engine sees the oldest entry through a valid/ready handshake. Entries leave strictly in the order they were accepted.

Top module: `rq_admit`

## Requirements
- R1: Entries are presented on the downstream port strictly in acceptance order, and the presented entry does not change until it is popped.
- R2: The queue never holds more than DEPTH (default 4) transactions, and no grant is issued while it holds DEPTH.
- R3: A refused request leaves no trace. If its requester withdraws before a later grant, that transaction never appears downstream.
- R4: When a slot is free, the granted requester has the highest `req_prio` value (an unsigned number, larger means more urgent) among all requesters with `req_valid` set.
- R5: Among valid requesters sharing the highest priority, the search starts at the index one above the last granted requester and wraps modulo NREQ. After reset the search starts at index 0.
- R6: A pop and an accept in the same cycle leave the occupancy unchanged.
- R7: Each entry carries the requester's address, its write flag and the requester index. These appear on `dn_addr`, `dn_write` and `dn_id`, where `dn_id` is the bit position of that requester's `req_valid`.
- R8: `req_grant` is combinational, has at most one bit set, is set only for a requester whose `req_valid` is high, and applies to the current cycle only.
- R9: `dn_valid` is high exactly when the queue is non-empty. An entry is removed on a rising edge where both `dn_valid` and `dn_ready` are high.
- R10: After reset the queue is empty, `dn_valid` is low, and with no request present `req_grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request flag |
| req_prio | input | NREQ*PRIO_W | Per-requester priority, requester i at bits [i*PRIO_W +: PRIO_W] |
| req_addr | input | NREQ*ADDR_W | Per-requester address, requester i at bits [i*ADDR_W +: ADDR_W] |
| req_write | input | NREQ | Per-requester write flag (1 = write) |
| req_grant | output | NREQ | One-hot accept indication for the current cycle |
| dn_valid | output | 1 | Oldest entry is present |
| dn_ready | input | 1 | Downstream takes the oldest entry |
| dn_addr | output | ADDR_W | Address of the oldest entry |
| dn_write | output | 1 | Write flag of the oldest entry |
| dn_id | output | $clog2(NREQ) | Requester index of the oldest entry |

## Verification
The bench fills the queue with one requester that keeps requesting. It expects exactly four grants and then silence. A design that counted to five, or that latched refused requests, would show extra grants or extra addresses during the drain.

The bench also raises a top-priority request while the queue is full. It expects that request to take the first freed slot. An arbiter that let the waiting low-priority requester keep its place would put the wrong requester index there.

Tie cases are walked through a table so that the wrap of the rotating start index is visible. A design that restarts the search at index 0 after every grant would grant the wrong requester in those cases.

A push in the same cycle as a pop must leave exactly the expected number of entries to drain. An occupancy counter that lost or gained a unit would leave one entry too many or too few.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;

  // Index arithmetic that wraps around a ring of n positions.
  function automatic int wrap_add(int base, int off, int n);
    return (base + off) % n;
  endfunction

  // True when one priority level strictly outranks another.
  function automatic bit outranks(int a, int b);
    return a > b;
  endfunction

endpackage

// File: rtl/rq_arbiter.sv
`timescale 1ns/1ps
module rq_arbiter #(
  parameter int NREQ   = 4,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*PRIO_W-1:0]   req_prio,
  output logic [NREQ-1:0]          grant,
  output logic [$clog2(NREQ)-1:0]  grant_idx,
  output logic                     grant_any
);
  localparam int IDX_W = $clog2(NREQ);

  logic [PRIO_W-1:0] prio_arr [NREQ];
  logic [PRIO_W-1:0] top_prio;
  logic              seen;
  logic [IDX_W-1:0]  rr_ptr;
  logic [IDX_W-1:0]  pick;
  logic              found;
  int                scan_idx;

  for (genvar g = 0; g < NREQ; g++) begin : g_unpack
    assign prio_arr[g] = req_prio[g*PRIO_W +: PRIO_W];
  end

  // Highest priority level among the valid requesters.
  always_comb begin
    top_prio = '0;
    seen     = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_valid[i] && (!seen || rq_pkg::outranks(int'(prio_arr[i]), int'(top_prio)))) begin
        top_prio = prio_arr[i];
        seen     = 1'b1;
      end
    end
  end

  // Rotating search among requesters at that level.
  always_comb begin
    pick     = '0;
    found    = 1'b0;
    scan_idx = 0;
    for (int k = 0; k < NREQ; k++) begin
      scan_idx = rq_pkg::wrap_add(int'(rr_ptr), k, NREQ);
      if (!found && req_valid[scan_idx] && (prio_arr[scan_idx] == top_prio)) begin
        pick  = IDX_W'(scan_idx);
        found = 1'b1;
      end
    end
  end

  assign grant_any = found & enable;
  assign grant_idx = pick;
  assign grant     = grant_any ? (NREQ'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)         rr_ptr <= '0;
    else if (grant_any) rr_ptr <= IDX_W'(rq_pkg::wrap_add(int'(pick), 1, NREQ));
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0); // R8

  for (genvar a = 0; a < NREQ; a++) begin : g_prio_chk
    for (genvar b = 0; b < NREQ; b++) begin : g_pair
      AST_PRIO_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[a] && req_valid[b]) |-> (prio_arr[b] <= prio_arr[a])); // R4
    end
  end
endmodule

// File: rtl/rq_fifo.sv
`timescale 1ns/1ps
module rq_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         has_space
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_pop;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty = (count != '0);
  assign has_space = (count < CNT_W'(DEPTH));
  assign do_pop    = pop & not_empty;
  assign head      = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= step(wr_ptr);
      if (do_pop) rd_ptr <= step(rd_ptr);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !push); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty); // R9
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && do_pop) |=> (count == $past(count))); // R6
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !do_pop) |=> $stable(head)); // R1
endmodule

// File: rtl/rq_admit.sv
`timescale 1ns/1ps
module rq_admit #(
  parameter int NREQ   = 4,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*PRIO_W-1:0]   req_prio,
  input  logic [NREQ*ADDR_W-1:0]   req_addr,
  input  logic [NREQ-1:0]          req_write,
  output logic [NREQ-1:0]          req_grant,
  output logic                     dn_valid,
  input  logic                     dn_ready,
  output logic [ADDR_W-1:0]        dn_addr,
  output logic                     dn_write,
  output logic [$clog2(NREQ)-1:0]  dn_id
);
  localparam int IDX_W = $clog2(NREQ);
  localparam int ENT_W = IDX_W + 1 + ADDR_W;

  logic              slot_free;
  logic              accept;
  logic [IDX_W-1:0]  win_idx;
  logic [ENT_W-1:0]  entry_in;
  logic [ENT_W-1:0]  entry_head;
  logic              pop_evt;

  rq_arbiter #(.NREQ(NREQ), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (slot_free),
    .req_valid (req_valid),
    .req_prio  (req_prio),
    .grant     (req_grant),
    .grant_idx (win_idx),
    .grant_any (accept)
  );

  assign entry_in = {win_idx, req_write[win_idx], req_addr[win_idx*ADDR_W +: ADDR_W]};
  assign pop_evt  = dn_valid & dn_ready;

  rq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (entry_in),
    .pop       (pop_evt),
    .head      (entry_head),
    .not_empty (dn_valid),
    .has_space (slot_free)
  );

  assign dn_addr  = entry_head[ADDR_W-1:0];
  assign dn_write = entry_head[ADDR_W];
  assign dn_id    = entry_head[ENT_W-1 -: IDX_W];

  AST_GRANT_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant != '0) |-> slot_free); // R8
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dn_valid); // R9
endmodule

// File: tb/tb_rq_admit.sv
`timescale 1ns/1ps
module tb_rq_admit;
  localparam int NREQ = 4, PRIO_W = 2, ADDR_W = 16, DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0]        req_valid = '0;
  logic [NREQ*PRIO_W-1:0] req_prio  = '0;
  logic [NREQ*ADDR_W-1:0] req_addr  = '0;
  logic [NREQ-1:0]        req_write = 4'b1010;
  logic [NREQ-1:0]        req_grant;
  logic                   dn_valid;
  logic                   dn_ready = 1'b0;
  logic [ADDR_W-1:0]      dn_addr;
  logic                   dn_write;
  logic [1:0]             dn_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rq_admit #(.NREQ(NREQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
    .req_addr(req_addr), .req_write(req_write), .req_grant(req_grant),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_id(dn_id)
  );

  // {valid[3:0], prio[7:0], expected grant[3:0]}, walked from reset in order.
  localparam logic [15:0] VEC [10] = '{
    16'h1001, 16'hF002, 16'hF408, 16'h6384, 16'h5111,
    16'h5114, 16'h0000, 16'h9C38, 16'h9C31, 16'hE002
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = '0; dn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_addr(input int r, input logic [15:0] a);
    req_addr[r*ADDR_W +: ADDR_W] = a;
  endtask

  task automatic expect_head(input string tag, input logic [1:0] id, input logic [15:0] a);
    check(dn_valid === 1'b1, {tag, " valid"}, 32'(dn_valid), 32'd1);
    check(dn_id === id && dn_addr === a && dn_write === req_write[id], tag,
          {13'd0, dn_write, dn_id, dn_addr}, {13'd0, req_write[id], id, a});
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R10: empty after reset, no grant without requests
    check(dn_valid === 1'b0, "R10 dn_valid after reset", 32'(dn_valid), 32'd0);
    check(req_grant === '0, "R10 grant idle", 32'(req_grant), 32'd0);

    // Table walk: R4 priority, R5 rotation, R7 payload, R9 pop
    for (int v = 0; v < 10; v++) begin
      logic [3:0] exp_g;
      int exp_i;
      @(negedge clk);
      req_valid = VEC[v][15:12];
      req_prio  = VEC[v][11:4];
      exp_g     = VEC[v][3:0];
      for (int r = 0; r < NREQ; r++) set_addr(r, 16'(16'h1000 * (r + 1) + v));
      #1;
      check(req_grant === exp_g, $sformatf("R4/R5/R8 vector %0d grant", v), 32'(req_grant), 32'(exp_g));
      exp_i = 0;
      for (int r = 0; r < NREQ; r++) if (exp_g[r]) exp_i = r;
      @(posedge clk);
      @(negedge clk);
      req_valid = '0;
      if (exp_g != '0) begin
        expect_head($sformatf("R7 vector %0d entry", v), 2'(exp_i), 16'(16'h1000 * (exp_i + 1) + v));
        dn_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dn_ready = 1'b0;
      end
      #1;
      check(dn_valid === 1'b0, $sformatf("R9 vector %0d empty after pop", v), 32'(dn_valid), 32'd0);
    end

    // Fill: R2 cap at four, R3 refused requests leave no trace
    do_reset();
    req_prio = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req_valid = 4'b0001;
      set_addr(0, 16'(16'h0100 + k));
      #1;
      check(req_grant === ((k < DEPTH) ? 4'b0001 : 4'b0000), $sformatf("R2 fill cycle %0d grant", k),
            32'(req_grant), (k < DEPTH) ? 32'd1 : 32'd0);
      @(posedge clk);
    end
    // R4: high-priority newcomer takes the first freed slot
    @(negedge clk);
    req_valid = 4'b0011;
    req_prio  = 8'b0000_1100;
    set_addr(0, 16'h0106);
    set_addr(1, 16'h0BEE);
    dn_ready = 1'b1;
    #1;
    check(req_grant === 4'b0000, "R2 full refuses", 32'(req_grant), 32'd0);
    expect_head("R1 oldest first", 2'd0, 16'h0100);
    @(posedge clk);
    @(negedge clk);
    dn_ready = 1'b0;
    #1;
    check(req_grant === 4'b0010, "R4 newcomer wins freed slot", 32'(req_grant), 32'd2);
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    dn_ready  = 1'b1;
    expect_head("R1/R3 drain 1", 2'd0, 16'h0101);
    @(posedge clk); @(negedge clk);
    expect_head("R1/R3 drain 2", 2'd0, 16'h0102);
    @(posedge clk); @(negedge clk);
    expect_head("R1/R3 drain 3", 2'd0, 16'h0103);
    @(posedge clk); @(negedge clk);
    expect_head("R1/R4 drain 4", 2'd1, 16'h0BEE);
    @(posedge clk); @(negedge clk);
    check(dn_valid === 1'b0, "R3 no refused entry left", 32'(dn_valid), 32'd0);
    dn_ready = 1'b0;

    // R6: push and pop in one cycle keep occupancy
    req_prio = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_valid = 4'b0100;
      set_addr(2, 16'(16'h2000 + k));
      dn_ready = (k == 2);
      #1;
      check(req_grant === 4'b0100, $sformatf("R6 push %0d grant", k), 32'(req_grant), 32'd4);
      if (k == 2) expect_head("R6 head during push+pop", 2'd2, 16'h2000);
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = '0;
    dn_ready  = 1'b1;
    expect_head("R6 remaining 1", 2'd2, 16'h2001);
    @(posedge clk); @(negedge clk);
    expect_head("R6 remaining 2", 2'd2, 16'h2002);
    @(posedge clk); @(negedge clk);
    check(dn_valid === 1'b0, "R6 exactly two remained", 32'(dn_valid), 32'd0);
    dn_ready = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule